// File: doc/BRIEF.md
# Buffered Program Word Loader

This block runs the multi-write sequence that fills a flash program buffer before a programming operation. The command decoder hands control to it with a one-cycle setup strobe, at the moment it sees the buffered-program opcode, together with the target address. The address picks an aligned window of `DEPTH` words. The next bus write gives the word count, written as one less than the number of words. After that, the block takes exactly that many address/data writes and stores each word in a local buffer, at the offset given by its address inside the window.

Once the buffer is full, the block expects one more write carrying the confirm code. A correct confirm raises a one-clock start strobe to the write state machine. The strobe comes with the number of words and the window base, and the state machine reads the buffer through a separate combinational read port.

Three faults stop the sequence and return the block to idle: an over-range count, a load address outside the window, or a wrong confirm. Each raises a one-clock error pulse on both sequence-error status lines, and the buffer contents are never handed to programming.

Top module: `bufprog_loader`

## Requirements
- R1: After reset the block is idle (`busy_o` low), with `wsm_start_o` low and `seq_err_o` equal to 2'b00.
- R2: A `setup_i` strobe while idle sets `busy_o` in the next cycle. It fixes the window base to `setup_addr_i` with its low log2(DEPTH) bits cleared.
- R3: The first write after setup holds the count minus one. A value above DEPTH-1 (511 by default) gives `seq_err_o` = 2'b11 for one cycle and returns to idle.
- R4: A count value C in 0..DEPTH-1 makes the block accept exactly C+1 data writes. Any write among them, even one whose data is 0x00D0, is stored as data and never taken as a confirm.
- R5: A data write whose address bits above the low log2(DEPTH) differ from the window base gives `seq_err_o` = 2'b11 for one cycle and returns to idle.
- R6: After the last data write, a write whose low data byte is 0xD0 raises `wsm_start_o` for exactly one cycle. During that cycle `wsm_words_o` = C+1 and `wsm_base_o` = the window base, and the block then returns to idle.
- R7: After the last data write, a write whose low byte is not 0xD0 gives `seq_err_o` = 2'b11 for one cycle, returns to idle and never raises `wsm_start_o`.
- R8: A word loaded at address A is returned on `rd_data_o` when `rd_idx_i` equals the low log2(DEPTH) bits of A.
- R9: Bus writes while idle have no effect: `busy_o`, `wsm_start_o` and `seq_err_o` stay low.
- R10: `wsm_start_o` and `seq_err_o` are never active in the same cycle, and whenever either is active `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_i | input | 1 | One-cycle strobe from the decoder: buffered program opcode seen |
| setup_addr_i | input | ADDR_W | Target address of the setup write |
| wr_valid_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Bus write address |
| wr_data_i | input | DATA_W | Bus write data |
| rd_idx_i | input | log2(DEPTH) | Buffer read index from the write state machine |
| rd_data_o | output | DATA_W | Buffer word at `rd_idx_i` |
| busy_o | output | 1 | Sequence in progress |
| wsm_start_o | output | 1 | One-cycle start request to the write state machine |
| wsm_words_o | output | log2(DEPTH)+1 | Number of words loaded (count + 1) |
| wsm_base_o | output | ADDR_W | Window base address |
| seq_err_o | output | 2 | Sequence-error status bits, pulsed together on an abort |

## Verification
The properties check on every cycle that the start strobe lasts one clock and never coincides with an error, that an error always sets both bits and leaves the block idle, that the presented word count stays within 1..DEPTH, and that no outcome appears unless a sequence was in progress. The bench scenarios are needed for everything that depends on data values. This covers the count limit at 511 versus 512, the exact number of loads before the confirm is honoured, a 0x00D0 data word that must not be taken as a confirm, window violations, and the contents read back from the buffer.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;

    typedef enum logic [1:0] {
        BP_IDLE,
        BP_COUNT,
        BP_LOAD,
        BP_CONFIRM
    } bp_state_e;

    localparam logic [7:0] BP_CONFIRM_CODE = 8'hD0;

endpackage

// File: rtl/bufprog_window.sv
module bufprog_window #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 9
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [ADDR_W-IDX_W-1:0] tag_i,
    output logic                    inside_o,
    output logic [IDX_W-1:0]        offset_o
);

    // Upper address bits select the aligned window; lower bits index it.
    assign inside_o = (addr_i[ADDR_W-1:IDX_W] == tag_i);
    assign offset_o = addr_i[IDX_W-1:0];

endmodule

// File: rtl/bufprog_store.sv
module bufprog_store #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/bufprog_loader.sv
module bufprog_loader
    import bufprog_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 512,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_i,
    input  logic [ADDR_W-1:0] setup_addr_i,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              wsm_start_o,
    output logic [CNT_W-1:0]  wsm_words_o,
    output logic [ADDR_W-1:0] wsm_base_o,
    output logic [1:0]        seq_err_o
);

    localparam logic [DATA_W-1:0] COUNT_MAX = DATA_W'(DEPTH - 1);

    typedef struct packed {
        bp_state_e        st;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] left;
        logic [CNT_W-1:0] words;
        logic             start;
        logic [1:0]       err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             in_win;
    logic [IDX_W-1:0] win_off;
    logic             buf_we;
    logic             unused_setup_lo;

    assign unused_setup_lo = ^setup_addr_i[IDX_W-1:0];

    bufprog_window #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) window_i (
        .addr_i   (wr_addr_i),
        .tag_i    (ctl_q.tag),
        .inside_o (in_win),
        .offset_o (win_off)
    );

    bufprog_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) store_i (
        .clk     (clk),
        .we_i    (buf_we),
        .waddr_i (win_off),
        .wdata_i (wr_data_i),
        .raddr_i (rd_idx_i),
        .rdata_o (rd_data_o)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.err   = 2'b00;
        buf_we      = 1'b0;
        unique case (ctl_q.st)
            BP_IDLE: begin
                if (setup_i) begin
                    ctl_d.tag = setup_addr_i[ADDR_W-1:IDX_W];
                    ctl_d.st  = BP_COUNT;
                end
            end
            BP_COUNT: begin
                if (wr_valid_i) begin
                    if (wr_data_i > COUNT_MAX) begin
                        ctl_d.err = 2'b11;
                        ctl_d.st  = BP_IDLE;
                    end else begin
                        ctl_d.left  = wr_data_i[IDX_W-1:0];
                        ctl_d.words = CNT_W'(wr_data_i[IDX_W-1:0]) + CNT_W'(1);
                        ctl_d.st    = BP_LOAD;
                    end
                end
            end
            BP_LOAD: begin
                if (wr_valid_i) begin
                    if (!in_win) begin
                        ctl_d.err = 2'b11;
                        ctl_d.st  = BP_IDLE;
                    end else begin
                        buf_we = 1'b1;
                        if (ctl_q.left == '0) begin
                            ctl_d.st = BP_CONFIRM;
                        end else begin
                            ctl_d.left = ctl_q.left - IDX_W'(1);
                        end
                    end
                end
            end
            BP_CONFIRM: begin
                if (wr_valid_i) begin
                    if (wr_data_i[7:0] == BP_CONFIRM_CODE) begin
                        ctl_d.start = 1'b1;
                    end else begin
                        ctl_d.err = 2'b11;
                    end
                    ctl_d.st = BP_IDLE;
                end
            end
            default: ctl_d.st = BP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: BP_IDLE, tag: '0, left: '0, words: '0,
                       start: 1'b0, err: 2'b00};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o      = (ctl_q.st != BP_IDLE);
    assign wsm_start_o = ctl_q.start;
    assign wsm_words_o = ctl_q.words;
    assign wsm_base_o  = {ctl_q.tag, {IDX_W{1'b0}}};
    assign seq_err_o   = ctl_q.err;

endmodule

// File: rtl/bufprog_loader_chk.sv
module bufprog_loader_chk #(
    parameter int DEPTH = 512,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             wsm_start_o,
    input logic [CNT_W-1:0] wsm_words_o,
    input logic [1:0]       seq_err_o
);

    assert_start_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_start_o |=> !wsm_start_o);

    assert_words_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_start_o |-> (wsm_words_o >= CNT_W'(1) && wsm_words_o <= CNT_W'(DEPTH)));

    assert_err_both_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err_o != 2'b00) |-> (seq_err_o == 2'b11));

    assert_err_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err_o != 2'b00) |=> (seq_err_o == 2'b00));

    assert_start_excl_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wsm_start_o && (seq_err_o != 2'b00)));

    assert_idle_on_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wsm_start_o || (seq_err_o != 2'b00)) |-> !busy_o);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> (!wsm_start_o && seq_err_o == 2'b00));

endmodule

bind bufprog_loader bufprog_loader_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .wsm_start_o (wsm_start_o),
    .wsm_words_o (wsm_words_o),
    .seq_err_o   (seq_err_o)
);

// File: tb/bufprog_loader_tb.sv
`timescale 1ns/1ps
module bufprog_loader_tb_top;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 512;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = IDX_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              setup_i = 1'b0;
    logic [ADDR_W-1:0] setup_addr_i = '0;
    logic              wr_valid_i = 1'b0;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [IDX_W-1:0]  rd_idx_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic              busy_o;
    logic              wsm_start_o;
    logic [CNT_W-1:0]  wsm_words_o;
    logic [ADDR_W-1:0] wsm_base_o;
    logic [1:0]        seq_err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bufprog_loader #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .setup_i      (setup_i),
        .setup_addr_i (setup_addr_i),
        .wr_valid_i   (wr_valid_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_idx_i     (rd_idx_i),
        .rd_data_o    (rd_data_o),
        .busy_o       (busy_o),
        .wsm_start_o  (wsm_start_o),
        .wsm_words_o  (wsm_words_o),
        .wsm_base_o   (wsm_base_o),
        .seq_err_o    (seq_err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint actual, input longint expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
        end
    endtask

    task automatic do_setup(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        setup_i = 1'b1;
        setup_addr_i = a;
        @(negedge clk);
        setup_i = 1'b0;
    endtask

    // Returns at the negedge after the capturing edge: registered outputs are settled.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_valid_i = 1'b1;
        wr_addr_i = a;
        wr_data_i = d;
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    function automatic logic [DATA_W-1:0] pattern(input int i, input int seed);
        return DATA_W'((i * 16'h1357) ^ seed);
    endfunction

    // Full good sequence; checks R2, R4, R6, R8.
    task automatic run_good(input logic [ADDR_W-1:0] a, input int cnt, input int seed,
                            input string tag);
        logic [ADDR_W-1:0] base;
        base = a & ~ADDR_W'(DEPTH - 1);
        do_setup(a);
        check(busy_o == 1'b1, "R2", {tag, " busy after setup"}, busy_o, 1);
        do_write(a, DATA_W'(cnt));
        for (int i = 0; i <= cnt; i++) begin
            do_write(base + ADDR_W'(i), pattern(i, seed));
        end
        check(busy_o == 1'b1 && wsm_start_o == 1'b0, "R4",
              {tag, " waiting for confirm after loads"}, {busy_o, wsm_start_o}, 2'b10);
        do_write(base, 16'hA5D0);
        check(wsm_start_o == 1'b1, "R6", {tag, " start pulse"}, wsm_start_o, 1);
        check(wsm_words_o == CNT_W'(cnt + 1), "R6", {tag, " word count"}, wsm_words_o, cnt + 1);
        check(wsm_base_o == base, "R2", {tag, " window base"}, wsm_base_o, base);
        check(seq_err_o == 2'b00, "R10", {tag, " no error with start"}, seq_err_o, 0);
        check(busy_o == 1'b0, "R10", {tag, " idle with start"}, busy_o, 0);
        @(negedge clk);
        check(wsm_start_o == 1'b0, "R6", {tag, " start lasts one cycle"}, wsm_start_o, 0);
        for (int i = 0; i <= cnt; i += (cnt / 3) + 1) begin
            rd_idx_i = IDX_W'(i);
            #0.5;
            check(rd_data_o == pattern(i, seed), "R8", {tag, " buffer word"}, rd_data_o, pattern(i, seed));
        end
    endtask

    task automatic expect_abort(input string req, input string what);
        check(seq_err_o == 2'b11, req, {what, " error bits"}, seq_err_o, 2'b11);
        check(busy_o == 1'b0 && wsm_start_o == 1'b0, req, {what, " idle, no start"},
              {busy_o, wsm_start_o}, 0);
        @(negedge clk);
        check(seq_err_o == 2'b00, req, {what, " error pulse one cycle"}, seq_err_o, 0);
    endtask

    task automatic test_reset();
        check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        check(wsm_start_o == 1'b0, "R1", "start after reset", wsm_start_o, 0);
        check(seq_err_o == 2'b00, "R1", "err after reset", seq_err_o, 0);
    endtask

    task automatic test_idle_writes();
        do_write(24'h001000, 16'h0003);
        do_write(24'h001000, 16'h00D0);
        check(busy_o == 1'b0 && wsm_start_o == 1'b0 && seq_err_o == 2'b00, "R9",
              "idle writes ignored", {busy_o, wsm_start_o, seq_err_o}, 0);
    endtask

    task automatic test_count_over();
        do_setup(24'h004000);
        do_write(24'h004000, 16'd512);
        expect_abort("R3", "count 512");
        do_setup(24'h004000);
        do_write(24'h004000, 16'hFFFF);
        expect_abort("R3", "count 0xFFFF");
    endtask

    task automatic test_confirm_as_data();
        // Count 1 -> two loads; the first carries 0x00D0 and must be stored as data.
        do_setup(24'h006000);
        do_write(24'h006000, 16'd1);
        do_write(24'h006005, 16'h00D0);
        check(wsm_start_o == 1'b0 && busy_o == 1'b1, "R4", "0xD0 data not a confirm",
              {busy_o, wsm_start_o}, 2'b10);
        do_write(24'h006006, 16'h1111);
        do_write(24'h006000, 16'h00D0);
        check(wsm_start_o == 1'b1 && wsm_words_o == CNT_W'(2), "R6", "start after two loads",
              {wsm_start_o, wsm_words_o}, {1'b1, CNT_W'(2)});
        rd_idx_i = IDX_W'(5);
        #0.5;
        check(rd_data_o == 16'h00D0, "R8", "word at offset 5", rd_data_o, 16'h00D0);
    endtask

    task automatic test_window();
        do_setup(24'h008123);
        do_write(24'h008000, 16'd3);
        do_write(24'h008010, 16'h2222);
        do_write(24'h008200, 16'h3333);
        expect_abort("R5", "address above window");
        do_setup(24'h008123);
        do_write(24'h008000, 16'd0);
        do_write(24'h007FFF, 16'h4444);
        expect_abort("R5", "address below window");
    endtask

    task automatic test_bad_confirm();
        do_setup(24'h00A000);
        do_write(24'h00A000, 16'd2);
        for (int i = 0; i < 3; i++) do_write(24'h00A000 + ADDR_W'(i), 16'h5555);
        do_write(24'h00A000, 16'h00FF);
        expect_abort("R7", "wrong confirm");
        check(busy_o == 1'b0, "R7", "idle after wrong confirm", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle_writes();
        run_good(24'h001234, 3, 16'h0F0F, "four words");
        run_good(24'h003A00, 0, 16'h7E7E, "single word");
        test_count_over();
        test_confirm_as_data();
        test_window();
        test_bad_confirm();
        run_good(24'h00C1FF, 511, 16'hA5A5, "full buffer");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule